// File: doc/BRIEF.md
# Bounded-Latency Grant Starvation Monitor

This block watches one client (client A) of a resource shared by three clients and flags the case where A is left waiting with no excuse. A cycle counts as *unserved* when A is requesting, A's acknowledge is low, and neither of the two other clients is requesting. The monitor counts consecutive unserved cycles. Any cycle that is not unserved clears the count. That happens when A is served, when A withdraws its request, or when a competitor asks for the resource. If the run of unserved cycles goes beyond a parameterised bound (default three cycles), the monitor enters a violation state. That state is absorbing and only a reset leaves it.

The monitor is passive and sits beside an arbiter. It samples four single-bit levels on each rising clock edge. It reports a sticky violation flag, a one-cycle pulse on entry to the violation state, and the current length of the unserved run, saturated at the bound. All pins are plain control and status levels: no data flows through the block, so there is no valid/ready handshake and no back-pressure. Reset is synchronous and active high.

Top module: `grant_latency_monitor`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, `viol_sticky`, `viol_pulse` and `wait_cnt` are all 0.
- R2: Outside the violation state, each edge on which the unserved condition (`a_req`=1, `a_ack`=0, `b_req`=0, `c_req`=0) holds and `wait_cnt` is below `BOUND` raises `wait_cnt` by one.
- R3: Outside the violation state, an edge where `a_req` is 0 or `a_ack` is 1 returns `wait_cnt` to 0.
- R4: Outside the violation state, an edge where `b_req` or `c_req` is 1 cancels the obligation: `wait_cnt` returns to 0 even if A is requesting and not acknowledged.
- R5: A run of exactly `BOUND` consecutive unserved edges raises no violation. The next consecutive unserved edge (with `wait_cnt` equal to `BOUND`) sets `viol_sticky` and `viol_pulse` after that edge.
- R6: `viol_pulse` is high for exactly one cycle per entry into the violation state, and only in the first cycle in which `viol_sticky` is high.
- R7: Once `viol_sticky` is 1 it stays 1 whatever the inputs are, `wait_cnt` holds at `BOUND`, and no further pulse occurs until reset.
- R8: `wait_cnt` never exceeds `BOUND`.
- R9: A reset while in the violation state clears it, and counting starts again from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_req | input | 1 | Client A is in its requesting state |
| b_req | input | 1 | Client B is in its requesting state |
| c_req | input | 1 | Client C is in its requesting state |
| a_ack | input | 1 | Acknowledge to client A |
| viol_sticky | output | 1 | Violation seen; held until reset |
| viol_pulse | output | 1 | One-cycle strobe on entry into the violation state |
| wait_cnt | output | $clog2(BOUND+1) | Consecutive unserved cycles, saturated at BOUND |

## Verification
The properties assume that all four inputs are clean, synchronous levels that are valid at every rising edge. They also assume that `rst` is asserted for at least one edge before any check matters. They place no limit on input patterns: any mix of competing requests, acknowledges and withdrawals is legal. The bench changes inputs only on the falling edge and holds reset over the first edges. It drives unserved runs of every length around the bound, and it interrupts those runs in turn with an acknowledge, a withdrawal, a B request and a C request. After a violation it applies arbitrary input patterns, and then it resets and starts again.

// File: rtl/glm_pkg.sv
package glm_pkg;
  function automatic int glm_cnt_width(input int bound);
    return (bound < 1) ? 1 : $clog2(bound + 1);
  endfunction
endpackage

// File: rtl/glm_cond.sv
module glm_cond (
  input  logic a_req,
  input  logic b_req,
  input  logic c_req,
  input  logic a_ack,
  output logic unserved
);
  logic contended;
  always_comb begin
    contended = b_req | c_req;
    unserved  = a_req & ~a_ack & ~contended;
  end
endmodule

// File: rtl/glm_wait_ctr.sv
module glm_wait_ctr #(
  parameter int BOUND = 3,
  parameter int CW    = glm_pkg::glm_cnt_width(BOUND)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          unserved,
  input  logic          freeze,
  output logic [CW-1:0] cnt,
  output logic          at_bound
);
  localparam logic [CW-1:0] LIMIT = CW'(BOUND);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!freeze) begin
      if (!unserved)
        cnt_q <= '0;
      else if (cnt_q != LIMIT)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt      = cnt_q;
  assign at_bound = (cnt_q == LIMIT);
endmodule

// File: rtl/glm_viol.sv
module glm_viol (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic sticky,
  output logic pulse
);
  logic sticky_q, pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky_q <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      sticky_q <= sticky_q | fire;
      pulse_q  <= fire & ~sticky_q;
    end
  end

  assign sticky = sticky_q;
  assign pulse  = pulse_q;
endmodule

// File: rtl/grant_latency_monitor.sv
module grant_latency_monitor #(
  parameter int BOUND = 3,
  localparam int CW   = glm_pkg::glm_cnt_width(BOUND)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_req,
  input  logic          b_req,
  input  logic          c_req,
  input  logic          a_ack,
  output logic          viol_sticky,
  output logic          viol_pulse,
  output logic [CW-1:0] wait_cnt
);
  logic unserved;
  logic at_bound;
  logic fire;
  logic sticky_w;

  glm_cond u_cond (
    .a_req    (a_req),
    .b_req    (b_req),
    .c_req    (c_req),
    .a_ack    (a_ack),
    .unserved (unserved)
  );

  glm_wait_ctr #(.BOUND(BOUND), .CW(CW)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .unserved (unserved),
    .freeze   (sticky_w),
    .cnt      (wait_cnt),
    .at_bound (at_bound)
  );

  assign fire = unserved & at_bound & ~sticky_w;

  glm_viol u_viol (
    .clk    (clk),
    .rst    (rst),
    .fire   (fire),
    .sticky (sticky_w),
    .pulse  (viol_pulse)
  );

  assign viol_sticky = sticky_w;
endmodule

// File: rtl/glm_checker.sv
module glm_checker #(
  parameter int BOUND = 3,
  localparam int CW   = glm_pkg::glm_cnt_width(BOUND)
) (
  input logic          clk,
  input logic          rst,
  input logic          a_req,
  input logic          b_req,
  input logic          c_req,
  input logic          a_ack,
  input logic          viol_sticky,
  input logic          viol_pulse,
  input logic [CW-1:0] wait_cnt
);
  localparam logic [CW-1:0] BND = CW'(BOUND);

  logic idle_ok;
  assign idle_ok = a_req & ~a_ack & ~b_req & ~c_req;

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!viol_sticky && !viol_pulse && wait_cnt == '0)); // R1
  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    (!viol_sticky && idle_ok && wait_cnt < BND) |=> (wait_cnt == $past(wait_cnt) + 1'b1)); // R2
  AST_SERVED_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!viol_sticky && (!a_req || a_ack)) |=> (wait_cnt == '0)); // R3
  AST_CONTEND_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!viol_sticky && (b_req || c_req)) |=> (wait_cnt == '0)); // R4
  AST_ENTER_BAD: assert property (@(posedge clk) disable iff (rst)
    (!viol_sticky && idle_ok && wait_cnt == BND) |=> (viol_sticky && viol_pulse)); // R5
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    viol_pulse |=> !viol_pulse); // R6
  AST_PULSE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (!viol_sticky) |=> (viol_pulse == viol_sticky)); // R6
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    viol_sticky |=> (viol_sticky && wait_cnt == BND)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    wait_cnt <= BND); // R8
endmodule

bind grant_latency_monitor glm_checker #(.BOUND(BOUND)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .a_req       (a_req),
  .b_req       (b_req),
  .c_req       (c_req),
  .a_ack       (a_ack),
  .viol_sticky (viol_sticky),
  .viol_pulse  (viol_pulse),
  .wait_cnt    (wait_cnt)
);

// File: tb/grant_latency_monitor_tb.sv
module grant_latency_monitor_tb;
  localparam int BOUND = 3;
  localparam int CW    = glm_pkg::glm_cnt_width(BOUND);

  typedef struct {
    logic          sticky;
    logic          pulse;
    logic [CW-1:0] cnt;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_req = 1'b0, b_req = 1'b0, c_req = 1'b0, a_ack = 1'b0;
  logic          viol_sticky, viol_pulse;
  logic [CW-1:0] wait_cnt;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  exp_t sb_q[$];

  // reference model state
  logic          m_st  = 1'b0;
  logic          m_pl  = 1'b0;
  logic [CW-1:0] m_cnt = '0;

  always #10 clk = ~clk;

  grant_latency_monitor #(.BOUND(BOUND)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .a_req       (a_req),
    .b_req       (b_req),
    .c_req       (c_req),
    .a_ack       (a_ack),
    .viol_sticky (viol_sticky),
    .viol_pulse  (viol_pulse),
    .wait_cnt    (wait_cnt)
  );

  task automatic step(input logic r, input logic a, input logic b,
                      input logic c, input logic k, input string tag);
    logic cond;
    exp_t e;
    @(negedge clk);
    rst = r; a_req = a; b_req = b; c_req = c; a_ack = k;
    @(posedge clk);
    cond = a & ~k & ~b & ~c;
    if (r) begin
      m_st = 1'b0; m_pl = 1'b0; m_cnt = '0;
    end else begin
      m_pl = !m_st && cond && (int'(m_cnt) == BOUND);
      if (!m_st) begin
        if (m_pl) m_st = 1'b1;
        else if (!cond) m_cnt = '0;
        else if (int'(m_cnt) < BOUND) m_cnt = m_cnt + 1'b1;
      end
    end
    e.sticky = m_st; e.pulse = m_pl; e.cnt = m_cnt; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic run_unserved(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, tag);
  endtask

  // monitor: pop and compare away from the edge
  always @(posedge clk) begin
    #5;
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (viol_sticky !== e.sticky || viol_pulse !== e.pulse || wait_cnt !== e.cnt) begin
        errors++;
        $display("FAIL %s: got sticky=%0b pulse=%0b cnt=%0d, expected sticky=%0b pulse=%0b cnt=%0d",
                 e.tag, viol_sticky, viol_pulse, wait_cnt, e.sticky, e.pulse, e.cnt);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
    // R2 count up, R5 exactly BOUND runs do not violate, R3 ack clears
    run_unserved(BOUND, "R2");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R3_ack");
    run_unserved(2, "R2");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3_withdraw");
    // R4 competing requests cancel
    run_unserved(2, "R2");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R4_b");
    run_unserved(BOUND, "R5_nobad");
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R4_c");
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R4_all");
    // R5 violation after BOUND+1, R6 one-cycle pulse
    run_unserved(BOUND + 1, "R5");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
    // R7 absorbing under arbitrary inputs, R8 no overflow
    for (int i = 0; i < 16; i++)
      step(1'b0, logic'(i[0]), logic'(i[1]), logic'(i[2]), logic'(i[3]), "R7");
    run_unserved(4, "R8");
    // R9 reset clears violation
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
    run_unserved(2, "R9");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R3");
    run_unserved(BOUND + 3, "R8_run");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7_after");
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule